// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block holds the protection state of a byte-addressed serial memory and decides, cycle by cycle, whether a memory byte write or a status byte write may proceed. The serial command engine next to it hands over single-cycle strobes: enable writes, disable writes, a status byte to store, a memory write underway, and the end of the select period. The block also watches the active-low write-protect pin. In return it presents the status byte for a status read, a combinational verdict for the memory address being written, and a verdict for a status write.

Protection comes in tiers. A write-enable latch must be set before any write and is dropped automatically when the select period of any write-type command ends. Two block-protect bits fence off the upper quarter, the upper half or the whole of the address space. A pin-lock enable bit turns the hardware pin into a lock on the status byte. The retained protection bits are plain registers here, loaded from parameters at reset.

All interfaces are plain control and status pins. The strobes carry no handshake; the engine is expected to raise each for one clock, and nothing in the block can push back.

Top module: `wp_guard`

## Requirements
- R1: After reset the latch is 0 and the pin-lock and block-protect bits take the values of parameters RST_WPEN and RST_BP; the status byte reads {pin-lock, 000, BP1, BP0, latch, 0} with bit 7 = pin-lock, bit 3 = BP1, bit 2 = BP0, bit 1 = latch.
- R2: An enable strobe sets the latch one clock later. A status write never changes the latch: data bit 1 has no effect.
- R3: The latch clears one clock after a deselect strobe if that select period (including the deselect cycle itself) carried a disable, status-write or memory-write strobe. A deselect that ends any other command leaves the latch as it was.
- R4: Status bits 6, 5, 4 and 0 always read 0, whatever data is written.
- R5: The protected range follows BP1:BP0: 00 none; 01 the top quarter (addresses 1800h-1FFFh at the default 13-bit width); 10 the top half (1000h-1FFFh); 11 every address.
- R6: The memory write verdict is 1 exactly when the latch is 1 and the address is outside the protected range; neither the pin nor the pin-lock bit affects it.
- R7: The status write verdict is 1 exactly when the latch is 1 and either the pin-lock bit is 0 or the pin is high.
- R8: A status write accepted by R7 loads pin-lock from data bit 7 and BP1:BP0 from data bits 3:2 one clock later. A blocked one leaves them unchanged and still clears the latch at deselect.
- R9: The memory write verdict is combinational on the current address, so each byte of a sequential write is judged at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wen_i | input | 1 | Enable-writes command strobe |
| cmd_wdis_i | input | 1 | Disable-writes command strobe |
| cmd_stwr_i | input | 1 | Status byte write strobe, data on st_wdata_i |
| st_wdata_i | input | 8 | Status byte to store |
| cmd_memwr_i | input | 1 | Memory write command strobe |
| desel_i | input | 1 | Select period ends this cycle |
| wp_n_i | input | 1 | Hardware write-protect pin, active low |
| chk_addr_i | input | ADDR_W | Address of the memory byte being written |
| mem_wr_ok_o | output | 1 | Memory byte write allowed at chk_addr_i |
| st_wr_ok_o | output | 1 | Status byte write allowed |
| status_o | output | 8 | Status byte for reads |

## Verification
The cycle that matters is the one where a status write strobe and the deselect strobe coincide: the write must be judged with the latch still set, and the latch must then drop as the same edge closes the command. The bench provokes this by issuing each status write in the deselect cycle and also apart from it, with the pin high and low, and compares the status byte after the edge with a model of the register. It also sweeps every address under each block-protect setting, pin-lock value and pin level against an arithmetic limit.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int ST_W     = 8;
  localparam int ST_LOCK  = 7;
  localparam int ST_BPH   = 3;
  localparam int ST_BPL   = 2;
  localparam int ST_LATCH = 1;

  typedef struct packed {
    logic       lock;
    logic [1:0] bp;
  } prot_t;

  function automatic logic [ST_W-1:0] pack_status(prot_t p, logic latch);
    logic [ST_W-1:0] s;
    s           = '0;
    s[ST_LOCK]  = p.lock;
    s[ST_BPH]   = p.bp[1];
    s[ST_BPL]   = p.bp[0];
    s[ST_LATCH] = latch;
    return s;
  endfunction
endpackage

// File: rtl/wp_wel_latch.sv
module wp_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wtype_i,
  input  logic desel_i,
  output logic wel_o
);
  logic pend_q;
  logic wel_q;
  logic drop;

  assign drop  = desel_i && (pend_q || wtype_i);
  assign wel_o = wel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wel_q  <= 1'b0;
    end else begin
      if (desel_i)      pend_q <= 1'b0;
      else if (wtype_i) pend_q <= 1'b1;
      if (drop)         wel_q  <= 1'b0;
      else if (set_i)   wel_q  <= 1'b1;
    end
  end

  p_wel_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !drop) |=> wel_o);

  p_wel_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (desel_i && wtype_i) |=> !wel_o);

  p_wel_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (desel_i && !pend_q && !wtype_i && !set_i) |=> $stable(wel_o));
endmodule

// File: rtl/wp_prot_regs.sv
module wp_prot_regs
  import wp_pkg::*;
#(
  parameter logic       RST_WPEN = 1'b0,
  parameter logic [1:0] RST_BP   = 2'b00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic            ok_i,
  input  logic [ST_W-1:0] data_i,
  output prot_t           prot_o
);
  prot_t prot_q;
  assign prot_o = prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q.lock <= RST_WPEN;
      prot_q.bp   <= RST_BP;
    end else if (wr_i && ok_i) begin
      prot_q.lock <= data_i[ST_LOCK];
      prot_q.bp   <= {data_i[ST_BPH], data_i[ST_BPL]};
    end
  end

  p_blocked_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !ok_i) |=> $stable(prot_o));

  p_accept_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ok_i) |=> (prot_o.lock == $past(data_i[ST_LOCK])));
endmodule

// File: rtl/wp_range_chk.sv
module wp_range_chk #(
  parameter int ADDR_W = 13
) (
  input  logic [1:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int TOP = ADDR_W - 1;

  logic in_half;
  logic in_quarter;

  assign in_half    = addr_i[TOP];
  assign in_quarter = addr_i[TOP] && addr_i[TOP-1];

  always_comb begin
    unique case (bp_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = in_quarter;
      2'b10:   hit_o = in_half;
      default: hit_o = 1'b1;
    endcase
  end

  initial begin
    a_width_r5: assert (ADDR_W >= 2);
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int         ADDR_W   = 13,
  parameter logic       RST_WPEN = 1'b0,
  parameter logic [1:0] RST_BP   = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wen_i,
  input  logic              cmd_wdis_i,
  input  logic              cmd_stwr_i,
  input  logic [7:0]        st_wdata_i,
  input  logic              cmd_memwr_i,
  input  logic              desel_i,
  input  logic              wp_n_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              mem_wr_ok_o,
  output logic              st_wr_ok_o,
  output logic [7:0]        status_o
);
  logic  wel;
  logic  wtype;
  logic  hit;
  prot_t prot;

  assign wtype = cmd_wdis_i | cmd_stwr_i | cmd_memwr_i;

  wp_wel_latch i_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (cmd_wen_i),
    .wtype_i (wtype),
    .desel_i (desel_i),
    .wel_o   (wel)
  );

  assign st_wr_ok_o = wel && (!prot.lock || wp_n_i);

  wp_prot_regs #(
    .RST_WPEN (RST_WPEN),
    .RST_BP   (RST_BP)
  ) i_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (cmd_stwr_i),
    .ok_i   (st_wr_ok_o),
    .data_i (st_wdata_i),
    .prot_o (prot)
  );

  wp_range_chk #(.ADDR_W(ADDR_W)) i_range (
    .bp_i   (prot.bp),
    .addr_i (chk_addr_i),
    .hit_o  (hit)
  );

  assign mem_wr_ok_o = wel && !hit;
  assign status_o    = pack_status(prot, wel);

  p_mem_needs_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_ok_o |-> status_o[ST_LATCH]);

  p_all_fenced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[ST_BPH] && status_o[ST_BPL]) |-> !mem_wr_ok_o);

  p_pin_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[ST_LOCK] && !wp_n_i) |-> !st_wr_ok_o);

  p_zero_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stwr_i |=> (status_o[6:4] == 3'b000 && !status_o[0]));
endmodule

// File: tb/test_wp_guard.sv
module test_wp_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wen = 0, wdis = 0, stwr = 0, memwr = 0, desel = 0;
  logic          wp_n = 1'b1;
  logic [7:0]    wdata = '0;
  logic [AW-1:0] addr = '0;
  logic          mem_ok, st_ok;
  logic [7:0]    status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic       m_wel = 0, m_pend = 0, m_lock = 0;
  logic [1:0] m_bp = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_guard #(.ADDR_W(AW), .RST_WPEN(1'b0), .RST_BP(2'b00)) i_wp_guard (
    .clk(clk), .rst_n(rst_n), .cmd_wen_i(wen), .cmd_wdis_i(wdis),
    .cmd_stwr_i(stwr), .st_wdata_i(wdata), .cmd_memwr_i(memwr),
    .desel_i(desel), .wp_n_i(wp_n), .chk_addr_i(addr),
    .mem_wr_ok_o(mem_ok), .st_wr_ok_o(st_ok), .status_o(status)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {m_lock, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  function automatic logic exp_fenced(logic [1:0] bp, int a);
    int limit;
    case (bp)
      2'b00: limit = DEPTH;
      2'b01: limit = DEPTH - DEPTH / 4;
      2'b10: limit = DEPTH / 2;
      default: limit = 0;
    endcase
    return a >= limit;
  endfunction

  task automatic step(logic e, logic d, logic s, logic m, logic c, logic [7:0] dat);
    logic ok;
    @(negedge clk);
    wen = e; wdis = d; stwr = s; memwr = m; desel = c; wdata = dat;
    ok = m_wel && (!m_lock || wp_n);
    @(negedge clk);
    wen = 0; wdis = 0; stwr = 0; memwr = 0; desel = 0;
    if (s && ok) begin
      m_lock = dat[7];
      m_bp   = dat[3:2];
    end
    if (c && (m_pend || d || s || m)) begin
      m_wel = 0; m_pend = 0;
    end else begin
      if (e) m_wel = 1;
      if (d || s || m) m_pend = 1;
      if (c) m_pend = 0;
    end
  endtask

  task automatic program_status(logic [7:0] dat);
    wp_n = 1'b1;
    step(1, 0, 0, 0, 1, 8'h00);
    step(0, 0, 1, 0, 1, dat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status after reset", status, 8'h00);
    addr = 13'h0000; #1;
    chk("R6 no latch blocks memory", mem_ok, 0);
    chk("R7 no latch blocks status", st_ok, 0);

    // R2 enable strobe
    step(1, 0, 0, 0, 0, 8'h00);
    chk("R2 latch set", status, exp_status());
    // R3 deselect of non-write command keeps latch
    step(0, 0, 0, 0, 1, 8'h00);
    chk("R3 plain deselect keeps latch", status, 8'h02);

    // R4/R8 write all ones, latch remains until deselect
    step(0, 0, 1, 0, 0, 8'hFF);
    chk("R4 R8 accepted write", status, 8'h8E);
    step(0, 0, 0, 0, 1, 8'h00);
    chk("R3 deselect after status write", status, 8'h8C);

    // R2 status write with bit1 clear does not clear latch
    program_status(8'h00);
    step(1, 0, 0, 0, 1, 8'h00);
    step(0, 0, 1, 0, 0, 8'h0C);
    chk("R2 data bit1 clear keeps latch", status[1], 1'b1);
    step(0, 0, 0, 0, 1, 8'h00);
    chk("R2 R3 latch dropped later", status, exp_status());
    // R2 bit1 set without latch does nothing
    step(0, 0, 1, 0, 1, 8'h02);
    chk("R2 data bit1 cannot set latch", status, exp_status());
    chk("R8 blocked without latch", status[3:2], 2'b11);

    // Sweep protect settings, lock bit and pin level
    for (int bp = 0; bp < 4; bp++) begin
      for (int lk = 0; lk < 2; lk++) begin
        for (int pin = 0; pin < 2; pin++) begin
          logic [7:0] prog;
          logic [7:0] try_d;
          logic       exp_ok;
          prog = {lk[0], 3'b000, bp[1:0], 2'b00};
          program_status(prog);
          chk("R1 R8 programmed value", status, exp_status());
          step(1, 0, 0, 0, 1, 8'h00);
          wp_n = pin[0];
          #1;
          chk("R5 status with latch", status, exp_status());
          for (int a = 0; a < DEPTH; a++) begin
            addr = a[AW-1:0];
            #1;
            chk("R5 R6 R9 memory verdict", mem_ok, !exp_fenced(bp[1:0], a));
          end
          exp_ok = (lk == 0) || (pin == 1);
          chk("R7 status verdict", st_ok, exp_ok);
          try_d = ~prog;
          step(0, 0, 1, 0, 1, try_d);
          chk("R8 status write result", status, exp_status());
          chk("R3 R8 latch cleared", status[1], 1'b0);
          addr = '0; #1;
          chk("R6 memory blocked after drop", mem_ok, 0);
        end
      end
    end

    // R3 disable clears only at deselect
    wp_n = 1'b1;
    program_status(8'h00);
    step(1, 0, 0, 0, 1, 8'h00);
    step(0, 1, 0, 0, 0, 8'h00);
    chk("R3 disable waits for deselect", status[1], 1'b1);
    step(0, 0, 0, 0, 1, 8'h00);
    chk("R3 disable then deselect", status[1], 1'b0);

    // R3 memory write clears at deselect; R6 pin does not matter
    step(1, 0, 0, 0, 1, 8'h00);
    wp_n = 1'b0;
    addr = 13'h1FFF; #1;
    chk("R6 pin ignored for memory", mem_ok, 1'b1);
    step(0, 0, 0, 1, 0, 8'h00);
    chk("R3 memory write keeps latch mid-command", status[1], 1'b1);
    step(0, 0, 0, 0, 1, 8'h00);
    chk("R3 memory write then deselect", status[1], 1'b0);
    wp_n = 1'b1;

    // R2 enable with deselect in same cycle sets latch
    step(1, 0, 0, 0, 1, 8'h00);
    chk("R2 enable ending in deselect", status, exp_status());

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule